// File: doc/BRIEF.md
# Global Register Bank Switcher

The block holds the eight active global registers of a processor core together with four backing banks (normal, alternate, MMU and interrupt). A 12-bit processor-state value decides which bank is active: three of its bits pick the alternate, MMU or interrupt bank. When none of them is set, or more than one is, the normal bank is active.

A write to the state value that changes the bank selection starts a sixteen-cycle copy. In the first eight cycles the active registers are stored into the bank that was selected before. In the next eight cycles the newly selected bank is loaded into the active set. Only after this does the new state value become visible. While the copy runs, `busy` is high and the register and state ports are blocked. A state write that leaves the selection unchanged takes effect on the next clock and starts no copy. A build option for cores with level-based globals forces the alternate-select bit to zero on every state write.

Top module: `gbank_switch`

## Requirements
- R1: A state write stores its data ANDed with 0xF3F. The stored value appears on `stateOut`.
- R2: The selection is decoded from bits 11, 10 and 0 of the state. Exactly bit 0 set selects the alternate bank, exactly bit 10 the MMU bank, exactly bit 11 the interrupt bank, and none of them the normal bank. Each bank keeps its own contents across switches.
- R3: A selection with two or more of bits 11, 10 and 0 set uses the normal bank.
- R4: With parameter `LEVEL_GLOBALS` = 1, bit 0 of every state write is forced to zero before it is stored.
- R5: A state write whose bits 11, 10 and 0 equal the current ones updates `stateOut` on the next clock and leaves `busy` low.
- R6: A state write that changes bits 11, 10 or 0 raises `busy` for exactly 16 cycles. During that time the active set is stored to the old bank and then loaded from the new bank.
- R7: During the copy `stateOut` keeps the old value. The new value appears on the clock edge where `busy` falls.
- R8: While `busy` is high, register writes and state writes are ignored and `rdData` reads zero.
- R9: Register 0 of the active set always reads zero, and writes to it have no effect.
- R10: After reset, all banks, the active set and the state are zero, the normal bank is selected and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdIdx | input | 3 | Active register read index |
| rdData | output | 32 | Active register read data (combinational) |
| wrEn | input | 1 | Active register write enable |
| wrIdx | input | 3 | Active register write index |
| wrData | input | 32 | Active register write data |
| stWrEn | input | 1 | State write enable |
| stWrData | input | 12 | State write data |
| stateOut | output | 12 | Committed state value |
| busy | output | 1 | Bank copy in progress |

## Verification
The assertions assume that reset is held for at least one clock. They also assume that nothing outside the block relies on a write attempted while `busy` is high. The block drops such writes itself, so the assertions on the copy window hold under any input. The stimulus still tries writes and state writes in the middle of a copy, to show that they are discarded. Between copies it only changes inputs at falling edges, so the per-clock reference model sees the same inputs as the design.

// File: rtl/gbank_pkg.sv
package gbank_pkg;
  localparam int STATE_W = 12;
  localparam logic [STATE_W-1:0] WR_MASK = 12'hF3F;
  localparam logic [STATE_W-1:0] SEL_MASK = 12'hC01;

  typedef enum logic [1:0] {
    BANK_NORMAL = 2'd0,
    BANK_ALT    = 2'd1,
    BANK_MMU    = 2'd2,
    BANK_INTR   = 2'd3
  } bank_e;

  typedef struct packed {
    logic       saveEn;
    logic       loadEn;
    logic [2:0] idx;
    bank_e      oldBank;
    bank_e      newBank;
    logic       blocked;
  } strobe_t;

  function automatic bank_e decodeBank(input logic [STATE_W-1:0] st);
    case ({st[11], st[10], st[0]})
      3'b001:  return BANK_ALT;
      3'b010:  return BANK_MMU;
      3'b100:  return BANK_INTR;
      default: return BANK_NORMAL;
    endcase
  endfunction
endpackage

// File: rtl/gbank_ctrl.sv
module gbank_ctrl
  import gbank_pkg::*;
#(
  parameter int  NUM_REGS      = 8,
  parameter bit  LEVEL_GLOBALS = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stWrEn,
  input  logic [STATE_W-1:0] stWrData,
  output logic [STATE_W-1:0] stateOut,
  output logic               busy,
  output strobe_t            strobe
);
  localparam int COPY_LEN = 2 * NUM_REGS;
  localparam int CNT_W    = $clog2(COPY_LEN);

  logic [STATE_W-1:0] stateQ, pendQ;
  logic [CNT_W-1:0]   cnt;
  logic               busyQ;
  bank_e              oldQ, newQ;
  logic [STATE_W-1:0] masked;

  always_comb begin
    masked = stWrData & WR_MASK;
    if (LEVEL_GLOBALS) masked[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= '0;
      pendQ  <= '0;
      cnt    <= '0;
      busyQ  <= 1'b0;
      oldQ   <= BANK_NORMAL;
      newQ   <= BANK_NORMAL;
    end else if (busyQ) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(COPY_LEN - 1)) begin
        busyQ  <= 1'b0;
        stateQ <= pendQ;
      end
    end else if (stWrEn) begin
      if ((masked & SEL_MASK) != (stateQ & SEL_MASK)) begin
        busyQ <= 1'b1;
        cnt   <= '0;
        pendQ <= masked;
        oldQ  <= decodeBank(stateQ);
        newQ  <= decodeBank(masked);
      end else begin
        stateQ <= masked;
      end
    end
  end

  always_comb begin
    strobe.saveEn  = busyQ && (cnt < CNT_W'(NUM_REGS));
    strobe.loadEn  = busyQ && (cnt >= CNT_W'(NUM_REGS));
    strobe.idx     = cnt[2:0];
    strobe.oldBank = oldQ;
    strobe.newBank = newQ;
    strobe.blocked = busyQ;
  end

  assign stateOut = stateQ;
  assign busy     = busyQ;

  AST_STATE_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut & ~WR_MASK) == '0); // R1
  AST_COPY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt == CNT_W'(COPY_LEN - 1)) |=> !busy); // R6
  AST_STATE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != CNT_W'(COPY_LEN - 1)) |=> $stable(stateOut)); // R7
  AST_COPY_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (cnt == '0)); // R6

  generate
    if (LEVEL_GLOBALS) begin : g_lvl
      AST_NO_ALT_BIT: assert property (@(posedge clk) disable iff (!rstN)
        stateOut[0] == 1'b0); // R4
    end
  endgenerate
endmodule

// File: rtl/gbank_dp.sv
module gbank_dp
  import gbank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [2:0]          rdIdx,
  output logic [DATA_W-1:0]   rdData,
  input  logic                wrEn,
  input  logic [2:0]          wrIdx,
  input  logic [DATA_W-1:0]   wrData
);
  localparam int NUM_BANKS = 4;

  logic [DATA_W-1:0] active [NUM_REGS];
  logic [DATA_W-1:0] bank   [NUM_BANKS][NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        active[i] <= '0;
        for (int b = 0; b < NUM_BANKS; b++) bank[b][i] <= '0;
      end
    end else begin
      if (strobe.saveEn)
        bank[strobe.oldBank][strobe.idx] <= active[strobe.idx];
      if (strobe.loadEn && strobe.idx != 3'd0)
        active[strobe.idx] <= bank[strobe.newBank][strobe.idx];
      if (wrEn && !strobe.blocked && wrIdx != 3'd0)
        active[wrIdx] <= wrData;
    end
  end

  always_comb begin
    if (strobe.blocked || rdIdx == 3'd0) rdData = '0;
    else                                 rdData = active[rdIdx];
  end

  AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    active[0] == '0); // R9
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.saveEn && strobe.loadEn)); // R6
  AST_BUSY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.blocked |-> rdData == '0); // R8
  AST_BLOCK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.blocked && !strobe.loadEn && wrEn) |=> $stable(active[wrIdx])); // R8
endmodule

// File: rtl/gbank_switch.sv
module gbank_switch
  import gbank_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter bit LEVEL_GLOBALS = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [2:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stWrEn,
  input  logic [11:0]       stWrData,
  output logic [11:0]       stateOut,
  output logic              busy
);
  localparam int NUM_REGS = 8;
  strobe_t strobe;

  gbank_ctrl #(.NUM_REGS(NUM_REGS), .LEVEL_GLOBALS(LEVEL_GLOBALS)) u_ctrl (
    .clk(clk), .rstN(rstN), .stWrEn(stWrEn), .stWrData(stWrData),
    .stateOut(stateOut), .busy(busy), .strobe(strobe)
  );

  gbank_dp #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdIdx(rdIdx), .rdData(rdData),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData)
  );
endmodule

// File: tb/gbank_switch_bench.sv
module gbank_switch_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  rdIdx = '0;
  logic [31:0] rdData;
  logic        wrEn = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        stWrEn = 1'b0;
  logic [11:0] stWrData = '0;
  logic [11:0] stateOut;
  logic        busy;

  logic        gStWrEn = 1'b0;
  logic [11:0] gStWrData = '0;
  logic [31:0] gRdData;
  logic [11:0] gStateOut;
  logic        gBusy;

  always #10 clk = ~clk;

  gbank_switch u_gbank_switch (
    .clk(clk), .rstN(rstN), .rdIdx(rdIdx), .rdData(rdData), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrData(wrData), .stWrEn(stWrEn), .stWrData(stWrData),
    .stateOut(stateOut), .busy(busy)
  );

  gbank_switch #(.LEVEL_GLOBALS(1'b1)) u_gbank_switch_lvl (
    .clk(clk), .rstN(rstN), .rdIdx(3'd0), .rdData(gRdData), .wrEn(1'b0),
    .wrIdx(3'd0), .wrData(32'd0), .stWrEn(gStWrEn), .stWrData(gStWrData),
    .stateOut(gStateOut), .busy(gBusy)
  );

  int compared = 0;
  int mismatched = 0;
  string curReq = "R10";

  // behavioural reference
  logic [31:0] mAct [8];
  logic [31:0] mBank [4][8];
  logic [11:0] mState, mPend;
  int mBusyLeft;
  int mOld, mNew;

  function automatic int bankOf(input logic [11:0] s);
    if (s[11] + s[10] + s[0] != 1) return 0;
    if (s[0]) return 1;
    if (s[10]) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin
        mAct[i] = 0;
        for (int b = 0; b < 4; b++) mBank[b][i] = 0;
      end
      mState = 0; mBusyLeft = 0; mPend = 0; mOld = 0; mNew = 0;
    end else if (mBusyLeft > 0) begin
      mBusyLeft--;
      if (mBusyLeft == 0) begin
        for (int i = 0; i < 8; i++) mBank[mOld][i] = mAct[i];
        for (int i = 1; i < 8; i++) mAct[i] = mBank[mNew][i];
        mState = mPend;
      end
    end else begin
      if (wrEn && wrIdx != 0) mAct[wrIdx] = wrData;
      if (stWrEn) begin
        logic [11:0] m;
        m = stWrData & 12'hF3F;
        if ((m & 12'hC01) != (mState & 12'hC01)) begin
          mBusyLeft = 16; mPend = m;
          mOld = bankOf(mState); mNew = bankOf(m);
        end else mState = m;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk({curReq, " busy"}, {31'd0, busy}, {31'd0, mBusyLeft > 0});
      chk({curReq, " state"}, {20'd0, stateOut}, {20'd0, mState});
      chk({curReq, " rdData"}, rdData,
          (mBusyLeft > 0 || rdIdx == 0) ? 32'd0 : mAct[rdIdx]);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    rdIdx <= 3'(cyc);
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input int i, input logic [31:0] d);
    @(negedge clk); #1; wrEn = 1; wrIdx = 3'(i); wrData = d;
    @(negedge clk); #1; wrEn = 0;
  endtask

  task automatic wst(input logic [11:0] d);
    @(negedge clk); #1; stWrEn = 1; stWrData = d;
    @(negedge clk); #1; stWrEn = 0;
  endtask

  initial begin
    stepN(3);
    curReq = "R10";
    #1 rstN = 1;
    stepN(10);
    // R9: writes to register 0 ignored
    curReq = "R9";
    wreg(0, 32'hDEAD_BEEF);
    for (int i = 1; i < 8; i++) wreg(i, 32'h1000_0000 + i);
    stepN(9);
    // R6: switch to alternate bank, copy lasts 16 cycles
    curReq = "R6";
    wst(12'h001);
    stepN(20);
    for (int i = 1; i < 8; i++) wreg(i, 32'hA000_0000 + i);
    stepN(9);
    // R8: blocked writes during copy
    curReq = "R8";
    wst(12'h400);
    wreg(3, 32'h5555_5555);
    wst(12'h800);
    stepN(16);
    for (int i = 1; i < 8; i++) wreg(i, 32'hB000_0000 + i);
    // R2: interrupt bank then back to normal and alternate
    curReq = "R2";
    wst(12'h800);
    stepN(18);
    wreg(5, 32'hC000_0005);
    wst(12'h000);
    stepN(18);
    wst(12'h001);
    stepN(18);
    wst(12'h400);
    stepN(18);
    // R1, R3: unmasked bits and malformed selection -> normal bank
    curReq = "R3";
    wst(12'hFFF);
    stepN(18);
    curReq = "R1";
    wst(12'h0F0);
    stepN(18);
    // R5: same selection, no copy
    curReq = "R5";
    wst(12'h0C2);
    stepN(3);
    wst(12'h801);
    stepN(18);
    wst(12'hC00);
    stepN(18);
    // R4: level-based option
    @(negedge clk); #1; gStWrEn = 1; gStWrData = 12'h001;
    @(negedge clk); #1; gStWrEn = 0;
    stepN(1);
    chk("R4 state", {20'd0, gStateOut}, 32'd0);
    chk("R4 busy", {31'd0, gBusy}, 32'd0);
    @(negedge clk); #1; gStWrEn = 1; gStWrData = 12'h403;
    @(negedge clk); #1; gStWrEn = 0;
    chk("R4 busy copy", {31'd0, gBusy}, 32'd1);
    stepN(17);
    chk("R4 state after", {20'd0, gStateOut}, 32'h402);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule